// File: doc/BRIEF.md
# Strip-Swept Affine-Gap Local Alignment Engine

This block scores the best local alignment between two nucleotide sequences. It uses the affine-gap dynamic-programming recurrence. The score matrix is not computed in one pass. It is cut into vertical strips, each `BW` columns wide. The caller loads one strip of second-sequence residues into the engine. It then streams the first sequence through, one residue per cycle. On each such cycle the engine finishes a whole row of the strip: H, E and F for all `BW` columns.

The H and E values of a strip's last column are kept in an internal two-bank boundary store, one entry per row. The next strip reads them back as its left edge. The banks trade roles at every strip load, so the strip being read is never the strip being written. The same last-column values also appear on the boundary output for observation.

A running maximum over every H computed since the last alignment start gives the optimal local score. A sticky flag reports when a cell score had to be clipped at the score width's ceiling. Strips are processed left to right, in the order they are loaded. The second sequence is padded with dummy residues up to a multiple of `BW`.

Top module: `swStripAligner`

## Requirements
- R1: Residue codes are 3 bits: 0 = A, 1 = C, 2 = G, 3 = T, and 4 to 7 are padding. Each cell computes E = max(Hleft − 7, Eleft − 2), F = max(Hup − 7, Fup − 2) and H = max(0, Hdiag + s, E, F). Here s is +1 for equal nucleotides and −3 otherwise.
- R2: The first strip after an alignment start sees zero H and E on its left edge. Every strip starts from zero H and F in its top row, and from a zero diagonal on its first row.
- R3: A row accepted on a clock edge drives `bndValid` high after that edge. `bndH` and `bndE` then carry the H and E of the strip's rightmost column for that row. With no accepted row, `bndValid` is low after the edge.
- R4: Row r of any strip after the first uses, as its left edge, the H and E that the previous strip produced at row r. Its diagonal on row r is the previous strip's H at row r − 1.
- R5: `bestScore` equals the largest H of every row accepted since the last alignment start. It is updated on the same edge that accepts the row.
- R6: A padding residue on either side scores −3 against anything, padding included, so padding can never raise `bestScore`.
- R7: Penalty subtractions clip at the most negative score value. Hdiag + s clips at the most positive value. Such a ceiling clip sets `overflow`, which stays set until the next alignment start.
- R8: `alnStart` clears `bestScore` and `overflow` and marks the next strip as the first. A strip load or row presented in the same cycle as `alnStart` is ignored. A row presented together with a strip load is ignored.
- R9: Lane j of `stripLoadRes` (bits 3j+2 down to 3j) is column j of the strip, with lane 0 leftmost.
- R10: After reset, `bndValid` and `overflow` are low and `bestScore` is zero. The next strip is treated as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alnStart | input | 1 | Begin a new alignment |
| stripLoadValid | input | 1 | Load a strip of second-sequence residues |
| stripLoadRes | input | BW*3 | Strip residues, lane 0 leftmost |
| rowValid | input | 1 | Present one first-sequence residue (one row) |
| rowRes | input | 3 | First-sequence residue for this row |
| bndValid | output | 1 | Boundary outputs valid for the row just accepted |
| bndH | output | SCORE_W | H of the strip's last column, signed |
| bndE | output | SCORE_W | E of the strip's last column, signed |
| bestScore | output | SCORE_W | Running maximum H, signed |
| overflow | output | 1 | Sticky ceiling-clip flag |

## Verification
Each row's last-column H and E leave the block one cycle after the row is accepted. A wrong value held in the row store or the column store therefore reaches `bndH` and `bndE` no later than the next row of the same strip, since the following row reads that store directly. A bank-swap or boundary-read error shows on the first rows of the second strip. A wrong diagonal carried across the strip edge also shows there. A fault in the running maximum or the sticky clip flag is visible at `bestScore` and `overflow` one edge after the offending row, and stays visible until the next start.

// File: rtl/swAlignPkg.sv
package swAlignPkg;

  localparam int RES_W   = 3;
  localparam int MATCH_SC = 1;
  localparam int MISS_SC  = -3;
  localparam int GAP_OE   = 7;
  localparam int GAP_EXT  = 2;

  typedef struct packed {
    logic clearAln;
    logic loadStrip;
    logic rowGo;
    logic zeroBnd;
    logic rdBank;
  } ctrlStrobe_t;

  function automatic int substScore(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b);
    if (a[RES_W-1] || b[RES_W-1]) return MISS_SC;
    return (a == b) ? MATCH_SC : MISS_SC;
  endfunction

endpackage

// File: rtl/swCell.sv
module swCell
  import swAlignPkg::*;
#(
  parameter int SCORE_W = 16
) (
  input  logic [RES_W-1:0]          resA,
  input  logic [RES_W-1:0]          resB,
  input  logic signed [SCORE_W-1:0] hDiag,
  input  logic signed [SCORE_W-1:0] hUp,
  input  logic signed [SCORE_W-1:0] fUp,
  input  logic signed [SCORE_W-1:0] hLeft,
  input  logic signed [SCORE_W-1:0] eLeft,
  output logic signed [SCORE_W-1:0] hOut,
  output logic signed [SCORE_W-1:0] eOut,
  output logic signed [SCORE_W-1:0] fOut,
  output logic                      satHit
);

  localparam int EXT = SCORE_W + 1;
  localparam logic signed [EXT-1:0] MAXV    = {2'b00, {(SCORE_W-1){1'b1}}};
  localparam logic signed [EXT-1:0] MINV    = {2'b11, {(SCORE_W-1){1'b0}}};
  localparam logic signed [EXT-1:0] PEN_OE  = EXT'(GAP_OE);
  localparam logic signed [EXT-1:0] PEN_EXT = EXT'(GAP_EXT);

  function automatic logic signed [SCORE_W-1:0] clip(input logic signed [EXT-1:0] v);
    if (v > MAXV) return MAXV[SCORE_W-1:0];
    if (v < MINV) return MINV[SCORE_W-1:0];
    return v[SCORE_W-1:0];
  endfunction

  logic signed [EXT-1:0]     subst;
  logic signed [EXT-1:0]     diagSum;
  logic signed [SCORE_W-1:0] diagSat;
  logic signed [SCORE_W-1:0] eOpen, eExt, fOpen, fExt;
  logic signed [SCORE_W-1:0] eVal, fVal, hVal;

  always_comb begin
    subst   = EXT'(substScore(resA, resB));
    diagSum = EXT'(hDiag) + subst;
    satHit  = (diagSum > MAXV);
    diagSat = clip(diagSum);

    eOpen = clip(EXT'(hLeft) - PEN_OE);
    eExt  = clip(EXT'(eLeft) - PEN_EXT);
    eVal  = (eExt > eOpen) ? eExt : eOpen;

    fOpen = clip(EXT'(hUp) - PEN_OE);
    fExt  = clip(EXT'(fUp) - PEN_EXT);
    fVal  = (fExt > fOpen) ? fExt : fOpen;

    hVal = '0;
    if (diagSat > hVal) hVal = diagSat;
    if (eVal > hVal)    hVal = eVal;
    if (fVal > hVal)    hVal = fVal;

    hOut = hVal;
    eOut = eVal;
    fOut = fVal;
  end

endmodule

// File: rtl/swBndBuf.sv
module swBndBuf #(
  parameter int SCORE_W = 16,
  parameter int DEPTH   = 64,
  parameter int AW      = 6
) (
  input  logic                      clk,
  input  logic                      wrEn,
  input  logic                      wrBank,
  input  logic [AW-1:0]             wrAddr,
  input  logic signed [SCORE_W-1:0] wrH,
  input  logic signed [SCORE_W-1:0] wrE,
  input  logic                      rdBank,
  input  logic [AW-1:0]             rdAddr,
  output logic signed [SCORE_W-1:0] rdH,
  output logic signed [SCORE_W-1:0] rdE
);

  logic signed [SCORE_W-1:0] memH [2][DEPTH];
  logic signed [SCORE_W-1:0] memE [2][DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      memH[wrBank][wrAddr] <= wrH;
      memE[wrBank][wrAddr] <= wrE;
    end
  end

  assign rdH = memH[rdBank][rdAddr];
  assign rdE = memE[rdBank][rdAddr];

endmodule

// File: rtl/swCtrl.sv
module swCtrl
  import swAlignPkg::*;
#(
  parameter int ROW_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alnStart,
  input  logic              stripLoadValid,
  input  logic              rowValid,
  output ctrlStrobe_t       strobe,
  output logic [ROW_AW-1:0] rowAddr
);

  logic              firstPending;
  logic              zeroBnd;
  logic              bankSel;
  logic [ROW_AW-1:0] rowCnt;

  always_comb begin
    strobe.clearAln  = alnStart;
    strobe.loadStrip = stripLoadValid & ~alnStart;
    strobe.rowGo     = rowValid & ~alnStart & ~stripLoadValid;
    strobe.zeroBnd   = zeroBnd;
    strobe.rdBank    = bankSel;
  end

  assign rowAddr = rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPending <= 1'b1;
      zeroBnd      <= 1'b1;
      bankSel      <= 1'b0;
      rowCnt       <= '0;
    end else if (strobe.clearAln) begin
      firstPending <= 1'b1;
    end else if (strobe.loadStrip) begin
      zeroBnd      <= firstPending;
      firstPending <= 1'b0;
      if (!firstPending) bankSel <= ~bankSel;
      rowCnt       <= '0;
    end else if (strobe.rowGo) begin
      rowCnt <= rowCnt + 1'b1;
    end
  end

endmodule

// File: rtl/swDatapath.sv
module swDatapath
  import swAlignPkg::*;
#(
  parameter int BW       = 4,
  parameter int SCORE_W  = 16,
  parameter int MAX_ROWS = 64,
  parameter int ROW_AW   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [ROW_AW-1:0]         rowAddr,
  input  logic [BW*RES_W-1:0]       stripLoadRes,
  input  logic [RES_W-1:0]          rowRes,
  output logic                      bndValid,
  output logic signed [SCORE_W-1:0] bndH,
  output logic signed [SCORE_W-1:0] bndE,
  output logic signed [SCORE_W-1:0] bestScore,
  output logic                      overflow
);

  typedef logic signed [SCORE_W-1:0] score_t;

  score_t                hRow [BW];
  score_t                fRow [BW];
  score_t                bndDiag;
  logic [BW*RES_W-1:0]   stripRes;
  score_t                cellH [BW];
  score_t                cellE [BW];
  score_t                cellF [BW];
  logic [BW-1:0]         cellSat;
  score_t                bufH, bufE, leftH, leftE, rowMax;

  swBndBuf #(
    .SCORE_W(SCORE_W),
    .DEPTH  (MAX_ROWS),
    .AW     (ROW_AW)
  ) u_bndBuf (
    .clk   (clk),
    .wrEn  (strobe.rowGo),
    .wrBank(~strobe.rdBank),
    .wrAddr(rowAddr),
    .wrH   (cellH[BW-1]),
    .wrE   (cellE[BW-1]),
    .rdBank(strobe.rdBank),
    .rdAddr(rowAddr),
    .rdH   (bufH),
    .rdE   (bufE)
  );

  assign leftH = strobe.zeroBnd ? '0 : bufH;
  assign leftE = strobe.zeroBnd ? '0 : bufE;

  for (genvar j = 0; j < BW; j++) begin : gCol
    score_t diagIn, inLeftH, inLeftE, hOut, eOut, fOut;
    logic   satOut;

    if (j == 0) begin : gEdge
      assign diagIn  = bndDiag;
      assign inLeftH = leftH;
      assign inLeftE = leftE;
    end else begin : gInner
      assign diagIn  = hRow[j-1];
      assign inLeftH = gCol[j-1].hOut;
      assign inLeftE = gCol[j-1].eOut;
    end

    swCell #(.SCORE_W(SCORE_W)) u_cell (
      .resA  (rowRes),
      .resB  (stripRes[j*RES_W +: RES_W]),
      .hDiag (diagIn),
      .hUp   (hRow[j]),
      .fUp   (fRow[j]),
      .hLeft (inLeftH),
      .eLeft (inLeftE),
      .hOut  (hOut),
      .eOut  (eOut),
      .fOut  (fOut),
      .satHit(satOut)
    );

    assign cellH[j]   = hOut;
    assign cellE[j]   = eOut;
    assign cellF[j]   = fOut;
    assign cellSat[j] = satOut;
  end

  always_comb begin
    rowMax = '0;
    for (int j = 0; j < BW; j++) begin
      if (cellH[j] > rowMax) rowMax = cellH[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < BW; j++) begin
        hRow[j] <= '0;
        fRow[j] <= '0;
      end
      bndDiag   <= '0;
      stripRes  <= '0;
      bndValid  <= 1'b0;
      bndH      <= '0;
      bndE      <= '0;
      bestScore <= '0;
      overflow  <= 1'b0;
    end else begin
      bndValid <= strobe.rowGo;
      if (strobe.clearAln) begin
        bestScore <= '0;
        overflow  <= 1'b0;
      end
      if (strobe.loadStrip) begin
        stripRes <= stripLoadRes;
        bndDiag  <= '0;
        for (int j = 0; j < BW; j++) begin
          hRow[j] <= '0;
          fRow[j] <= '0;
        end
      end else if (strobe.rowGo) begin
        for (int j = 0; j < BW; j++) begin
          hRow[j] <= cellH[j];
          fRow[j] <= cellF[j];
        end
        bndDiag <= leftH;
        bndH    <= cellH[BW-1];
        bndE    <= cellE[BW-1];
        if (rowMax > bestScore) bestScore <= rowMax;
        if (|cellSat) overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/swStripAligner.sv
module swStripAligner
  import swAlignPkg::*;
#(
  parameter int BW       = 4,
  parameter int SCORE_W  = 16,
  parameter int MAX_ROWS = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      alnStart,
  input  logic                      stripLoadValid,
  input  logic [BW*3-1:0]           stripLoadRes,
  input  logic                      rowValid,
  input  logic [2:0]                rowRes,
  output logic                      bndValid,
  output logic signed [SCORE_W-1:0] bndH,
  output logic signed [SCORE_W-1:0] bndE,
  output logic signed [SCORE_W-1:0] bestScore,
  output logic                      overflow
);

  localparam int ROW_AW = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1;

  ctrlStrobe_t       strobe;
  logic [ROW_AW-1:0] rowAddr;

  swCtrl #(.ROW_AW(ROW_AW)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .alnStart      (alnStart),
    .stripLoadValid(stripLoadValid),
    .rowValid      (rowValid),
    .strobe        (strobe),
    .rowAddr       (rowAddr)
  );

  swDatapath #(
    .BW      (BW),
    .SCORE_W (SCORE_W),
    .MAX_ROWS(MAX_ROWS),
    .ROW_AW  (ROW_AW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rowAddr     (rowAddr),
    .stripLoadRes(stripLoadRes),
    .rowRes      (rowRes),
    .bndValid    (bndValid),
    .bndH        (bndH),
    .bndE        (bndE),
    .bestScore   (bestScore),
    .overflow    (overflow)
  );

endmodule

// File: rtl/swStripAligner_chk.sv
module swStripAligner_chk #(
  parameter int SCORE_W = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      alnStart,
  input logic                      stripLoadValid,
  input logic                      rowValid,
  input logic                      bndValid,
  input logic signed [SCORE_W-1:0] bndH,
  input logic signed [SCORE_W-1:0] bndE,
  input logic signed [SCORE_W-1:0] bestScore,
  input logic                      overflow
);

  AST_BND_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (bndH >= 0)); // R1

  AST_E_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (bndE >= -7)); // R7

  AST_ROW_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && !alnStart && !stripLoadValid) |=> bndValid); // R3

  AST_ROW_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!rowValid || alnStart || stripLoadValid) |=> !bndValid); // R8

  AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !alnStart |=> (bestScore >= $past(bestScore))); // R5

  AST_BEST_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    bndValid |-> (bestScore >= bndH)); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    alnStart |=> (bestScore == 0 && !overflow)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !alnStart) |=> overflow); // R7

endmodule

bind swStripAligner swStripAligner_chk #(.SCORE_W(SCORE_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .alnStart      (alnStart),
  .stripLoadValid(stripLoadValid),
  .rowValid      (rowValid),
  .bndValid      (bndValid),
  .bndH          (bndH),
  .bndE          (bndE),
  .bestScore     (bestScore),
  .overflow      (overflow)
);

// File: tb/swStripAligner_tb.sv
module swStripAligner_tb;

  localparam int BW = 4;
  localparam int SW = 16;
  localparam int SL = 16;
  localparam int NV = 8;

  localparam logic [8*SL-1:0] V_S1 [NV] = '{
    "ACGT", "AAAA", "ACGTAC", "AAAAAAAA", "AAAACAAA", "TTACGTT", "ACGTACGT", "AAAAAAAAAAAA"};
  localparam logic [8*SL-1:0] V_S2 [NV] = '{
    "ACGT", "CCCC", "GTAC", "AAA", "AAAAAAA", "GGACGTGG", "TGCA", "AAAAAAGAAAAAA"};
  localparam int V_BEST [NV] = '{4, 0, 4, 3, 4, 4, 1, 8};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rstN;
  logic                 alnStart, stripLoadValid, rowValid;
  logic [BW*3-1:0]      stripLoadRes;
  logic [2:0]           rowRes;
  logic                 bndValid, overflow;
  logic signed [SW-1:0] bndH, bndE, bestScore;

  logic                 nStart, nLoad, nRow;
  logic [47:0]          nStripRes;
  logic [2:0]           nRowRes;
  logic                 nBndValid, nOvf;
  logic signed [4:0]    nBndH, nBndE, nBest;

  swStripAligner #(.BW(BW), .SCORE_W(SW), .MAX_ROWS(64)) u_dut (
    .clk(clk), .rstN(rstN), .alnStart(alnStart), .stripLoadValid(stripLoadValid),
    .stripLoadRes(stripLoadRes), .rowValid(rowValid), .rowRes(rowRes),
    .bndValid(bndValid), .bndH(bndH), .bndE(bndE), .bestScore(bestScore), .overflow(overflow));

  swStripAligner #(.BW(16), .SCORE_W(5), .MAX_ROWS(32)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .alnStart(nStart), .stripLoadValid(nLoad),
    .stripLoadRes(nStripRes), .rowValid(nRow), .rowRes(nRowRes),
    .bndValid(nBndValid), .bndH(nBndH), .bndE(nBndE), .bestScore(nBest), .overflow(nOvf));

  int nChecks = 0;
  int nFails  = 0;
  int mH [SL+1][SL+1];
  int mE [SL+1][SL+1];
  int mF [SL+1][SL+1];

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int strLen(input logic [8*SL-1:0] s);
    int n = 0;
    for (int k = 0; k < SL; k++) if (s[8*k +: 8] != 8'h00) n = k + 1;
    return n;
  endfunction

  function automatic int code(input logic [7:0] c);
    case (c)
      "A": return 0;
      "C": return 1;
      "G": return 2;
      "T": return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int refSub(input int a, input int b);
    if (a > 3 || b > 3) return -3;
    return (a == b) ? 1 : -3;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic runVec(input logic [8*SL-1:0] s1, input logic [8*SL-1:0] s2,
                        input int expBest, input int vi);
    int l1, l2, ns, n2, modelBest, col;
    int a [SL+1];
    int b [SL+1];
    l1 = strLen(s1);
    l2 = strLen(s2);
    ns = (l2 + BW - 1) / BW;
    n2 = ns * BW;
    for (int k = 0; k <= SL; k++) begin
      a[k] = 4;
      b[k] = 4;
    end
    for (int k = 0; k < l1; k++) a[k+1] = code(s1[8*(l1-1-k) +: 8]);
    for (int k = 0; k < l2; k++) b[k+1] = code(s2[8*(l2-1-k) +: 8]);
    modelBest = 0;
    for (int i = 0; i <= l1; i++) begin
      for (int j = 0; j <= n2; j++) begin
        if (i == 0 || j == 0) begin
          mH[i][j] = 0; mE[i][j] = 0; mF[i][j] = 0;
        end else begin
          mE[i][j] = imax(mH[i][j-1] - 7, mE[i][j-1] - 2);
          mF[i][j] = imax(mH[i-1][j] - 7, mF[i-1][j] - 2);
          mH[i][j] = imax(imax(0, mH[i-1][j-1] + refSub(a[i], b[j])), imax(mE[i][j], mF[i][j]));
          modelBest = imax(modelBest, mH[i][j]);
        end
      end
    end
    check($sformatf("R5 vector %0d model agrees with table", vi), modelBest, expBest);
    @(negedge clk) alnStart = 1'b1;
    @(negedge clk) alnStart = 1'b0;
    for (int s = 0; s < ns; s++) begin
      for (int c = 0; c < BW; c++) stripLoadRes[3*c +: 3] = 3'(b[s*BW + c + 1]); // R9 lane order
      stripLoadValid = 1'b1;
      @(negedge clk) stripLoadValid = 1'b0;
      col = (s + 1) * BW;
      for (int r = 1; r <= l1; r++) begin
        rowRes   = 3'(a[r]);
        rowValid = 1'b1;
        @(negedge clk) rowValid = 1'b0;
        check($sformatf("R3 vector %0d strip %0d row %0d bndValid", vi, s, r), bndValid, 1);
        // R1 recurrence; strips after the first depend on the R4 handoff
        check($sformatf("%s vector %0d strip %0d row %0d bndH", (s > 0) ? "R4" : "R1", vi, s, r),
              bndH, mH[r][col]);
        check($sformatf("%s vector %0d strip %0d row %0d bndE", (s > 0) ? "R4" : "R1", vi, s, r),
              bndE, mE[r][col]);
      end
    end
    check($sformatf("R5 R6 vector %0d bestScore", vi), bestScore, expBest);
    check($sformatf("R7 vector %0d no overflow", vi), overflow, 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    alnStart = 1'b0; stripLoadValid = 1'b0; rowValid = 1'b0;
    stripLoadRes = '0; rowRes = '0;
    nStart = 1'b0; nLoad = 1'b0; nRow = 1'b0; nStripRes = '0; nRowRes = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset bndValid", bndValid, 0);
    check("R10 reset bestScore", bestScore, 0);
    check("R10 reset overflow", overflow, 0);

    // R2 R9: first strip lanes A C G T against one row of T, zero left edge
    stripLoadRes = {3'd3, 3'd2, 3'd1, 3'd0};
    stripLoadValid = 1'b1;
    @(negedge clk) stripLoadValid = 1'b0;
    rowRes = 3'd3; rowValid = 1'b1;
    @(negedge clk) rowValid = 1'b0;
    check("R9 rightmost lane is T, bndH", bndH, 1);
    check("R2 zero left edge gives bndE", bndE, -7);
    check("R5 bestScore after one row", bestScore, 1);

    for (int v = 0; v < NV; v++) runVec(V_S1[v], V_S2[v], V_BEST[v], v);

    // R8: start with a row in the same cycle, then strip load with a row
    alnStart = 1'b1; rowValid = 1'b1; rowRes = 3'd0;
    @(negedge clk) alnStart = 1'b0; rowValid = 1'b0;
    check("R8 row ignored during start", bndValid, 0);
    check("R8 start clears bestScore", bestScore, 0);
    stripLoadRes = '0; stripLoadValid = 1'b1; rowValid = 1'b1;
    @(negedge clk) stripLoadValid = 1'b0; rowValid = 1'b0;
    check("R8 row ignored during strip load", bndValid, 0);
    check("R8 bestScore unchanged", bestScore, 0);

    // R6: padding strip and padding rows never score
    alnStart = 1'b1;
    @(negedge clk) alnStart = 1'b0;
    stripLoadRes = {BW{3'd4}}; stripLoadValid = 1'b1;
    @(negedge clk) stripLoadValid = 1'b0;
    for (int r = 0; r < 3; r++) begin
      rowRes = 3'd5; rowValid = 1'b1;
      @(negedge clk) rowValid = 1'b0;
      check("R6 padding row bndH", bndH, 0);
    end
    check("R6 padding bestScore", bestScore, 0);

    // R7: narrow instance, 5-bit scores, 16 matching rows on a 16-wide strip
    nStart = 1'b1;
    @(negedge clk) nStart = 1'b0;
    nStripRes = '0; nLoad = 1'b1;
    @(negedge clk) nLoad = 1'b0;
    for (int r = 1; r <= 15; r++) begin
      nRowRes = 3'd0; nRow = 1'b1;
      @(negedge clk) nRow = 1'b0;
    end
    check("R7 narrow best at fifteen rows", nBest, 15);
    check("R7 narrow no overflow yet", nOvf, 0);
    check("R7 narrow bndH at fifteen rows", nBndH, 15);
    nRow = 1'b1;
    @(negedge clk) nRow = 1'b0;
    check("R7 narrow best clipped", nBest, 15);
    check("R7 narrow overflow set", nOvf, 1);
    @(negedge clk);
    check("R7 overflow sticky", nOvf, 1);
    nStart = 1'b1;
    @(negedge clk) nStart = 1'b0;
    check("R8 start clears overflow", nOvf, 0);
    check("R8 start clears narrow best", nBest, 0);

    finishRun();
  end

endmodule